// File: doc/BRIEF.md
# Set-Dueling Re-Reference Replacement Controller

This block holds the replacement state of one set-associative cache bank. Every line carries a small re-reference prediction value (RRPV) and a valid bit. A request names a set, a way, an application and whether the lookup hit. On a hit the block marks the line as recently used. On a miss it chooses a victim way, fills it with an insertion value and reports the way. The tag and data arrays stay outside; they use the reported way.

Two insertion policies compete for each application. Static insertion always writes a configured value. Bimodal insertion writes the distant value except on a small configured fraction of fills. A few leader sets always use one of the two policies for a given application, and misses in those sets move a saturating signed counter for that application. All other sets, the followers, use whichever policy the counter currently favours. A mode pin turns the competition off.

Requests use a valid/ready handshake and only one can be in flight. `req_ready` is low from the cycle after a request is accepted until its response. The response is a single-cycle strobe with no back-pressure, so the consumer must take `resp_way` in the cycle `resp_valid` is high.

Top module: `rrip_repl_ctrl`

## Requirements
- R1: After reset every line is invalid, every application counter is 0, `req_ready` is 1, and `busy` and `resp_valid` are 0.
- R2: A request is taken on a clock edge where `req_valid` and `req_ready` are both 1. From the next cycle `busy` is 1 and `req_ready` is 0 until the response. `resp_valid` is high for exactly one cycle per request.
- R3: On a hit (`req_hit`=1) the RRPV of way `req_way` in `req_set` becomes 0. The response returns `req_way` two cycles after the accepting edge.
- R4: On a miss the victim is the lowest-numbered way that is invalid or whose RRPV equals the distant value 2^N-1, where N is `RRPV_BITS`.
- R5: If no way qualifies, all RRPVs of the set rise by one per clock cycle and the search repeats. Each pass delays the response by one cycle, and there are at most 2^N-1 passes.
- R6: The victim line becomes valid and takes the insertion value chosen for this fill.
- R7: Static insertion writes `ins_val`.
- R8: Bimodal insertion writes `ins_val` when an internal pseudo-random number in 0..99 is below `bip_pct`, and writes 2^N-1 otherwise. So `bip_pct`=0 always gives 2^N-1 and `bip_pct`>=100 always gives `ins_val`.
- R9: With stride S = NUM_SETS/32, a set whose index mod S equals 2a is a static leader for application a, and one equal to 2a+1 is a bimodal leader for a. Leaders use their own policy for requests of application a. For every other application the set is a follower.
- R10: While dueling is on, a miss from application a in its static leader increments its counter and a miss in its bimodal leader decrements it. The counter saturates at +2^K and -2^K, where K is `CTR_BITS`. Hits and follower misses do not change any counter.
- R11: A follower fill for application a uses static insertion when a's counter is <= 0 and bimodal insertion otherwise. Each application has its own counter.
- R12: With `duel_en`=0 every fill uses static insertion and the counters hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_set | input | $clog2(NUM_SETS) | Set index of the request |
| req_way | input | $clog2(NUM_WAYS) | Way that hit (ignored on a miss) |
| req_hit | input | 1 | 1 = lookup hit, 0 = miss needing a fill |
| req_app | input | $clog2(NUM_APPS) | Requesting application |
| duel_en | input | 1 | 1 = policy competition on, 0 = static everywhere |
| ins_val | input | RRPV_BITS | Static insertion value |
| bip_pct | input | 7 | Bimodal near-insertion chance in percent |
| busy | output | 1 | Request in progress |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_way | output | $clog2(NUM_WAYS) | Hit way or chosen victim way |

## Verification
A corrupted RRPV or valid bit shows at the ports on the next miss to that set. Either the reported victim way is wrong, or the response latency is wrong because the number of aging passes has changed. The bench fills whole sets and then probes them with one more miss. This makes the way and the latency of that probe reveal the value every line was given. A wrong policy counter only shows through follower fills. The scenarios therefore drive the counters across zero and into both saturation limits, and then probe a follower set. A wrong count appears on the first follower fill after the point where the counter's sign should have changed.

// File: rtl/rrip_pkg.sv
package rrip_pkg;
  typedef enum logic {ST_IDLE, ST_WORK} rrip_state_e;
endpackage

// File: rtl/rrip_lfsr.sv
module rrip_lfsr #(
  parameter int LFSR_W = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  output logic [6:0] pct_o
);
  localparam logic [LFSR_W-1:0] SEED = LFSR_W'(16'hACE1);
  localparam logic [LFSR_W-1:0] TAPS = LFSR_W'(16'hB400);

  logic [LFSR_W-1:0] lfsr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lfsr_q <= SEED;
    else if (lfsr_q[0]) lfsr_q <= (lfsr_q >> 1) ^ TAPS;
    else lfsr_q <= lfsr_q >> 1;
  end

  assign pct_o = 7'(lfsr_q % LFSR_W'(100));
endmodule

// File: rtl/rrip_duel.sv
module rrip_duel #(
  parameter int NUM_SETS = 256,
  parameter int NUM_APPS = 2,
  parameter int CTR_BITS = 3
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [$clog2(NUM_SETS)-1:0]        set_i,
  input  logic [$clog2(NUM_APPS)-1:0]        app_i,
  input  logic                               duel_en_i,
  input  logic                               miss_done_i,
  output logic                               use_bimodal_o,
  output logic [NUM_APPS*(CTR_BITS+2)-1:0]   ctr_flat_o
);
  localparam int STRIDE   = NUM_SETS / 32;
  localparam int STRIDE_W = $clog2(STRIDE);
  localparam int CW       = CTR_BITS + 2;
  localparam logic signed [CW-1:0] CMAX = CW'(2 ** CTR_BITS);
  localparam logic signed [CW-1:0] CMIN = -CMAX;

  logic signed [CW-1:0] ctr_q [NUM_APPS];
  logic [STRIDE_W-1:0]  res;
  logic                 lead_static, lead_bimodal;
  logic signed [CW-1:0] ctr_sel;

  assign res          = set_i[STRIDE_W-1:0];
  assign lead_static  = (int'(res) == 2 * int'(app_i));
  assign lead_bimodal = (int'(res) == 2 * int'(app_i) + 1);
  assign ctr_sel      = ctr_q[app_i];

  always_comb begin
    if (!duel_en_i)        use_bimodal_o = 1'b0;
    else if (lead_static)  use_bimodal_o = 1'b0;
    else if (lead_bimodal) use_bimodal_o = 1'b1;
    else                   use_bimodal_o = (ctr_sel > 0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int a = 0; a < NUM_APPS; a++) ctr_q[a] <= '0;
    end else if (miss_done_i && duel_en_i) begin
      for (int a = 0; a < NUM_APPS; a++) begin
        if (int'(app_i) == a) begin
          if (lead_static && ctr_q[a] != CMAX) ctr_q[a] <= ctr_q[a] + 1'b1;
          else if (lead_bimodal && ctr_q[a] != CMIN) ctr_q[a] <= ctr_q[a] - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < NUM_APPS; g++) begin : g_flat
    assign ctr_flat_o[g*CW +: CW] = ctr_q[g];
  end
endmodule

// File: rtl/rrip_set_state.sv
module rrip_set_state #(
  parameter int NUM_SETS  = 256,
  parameter int NUM_WAYS  = 4,
  parameter int RRPV_BITS = 2
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [$clog2(NUM_SETS)-1:0]   set_i,
  input  logic [$clog2(NUM_WAYS)-1:0]   way_i,
  input  logic                          hit_wr_i,
  input  logic                          age_i,
  input  logic                          fill_i,
  input  logic [RRPV_BITS-1:0]          fill_val_i,
  output logic                          found_o,
  output logic [$clog2(NUM_WAYS)-1:0]   victim_o
);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam logic [RRPV_BITS-1:0] DISTANT = '1;

  logic [RRPV_BITS-1:0] rrpv_q  [NUM_SETS][NUM_WAYS];
  logic                 valid_q [NUM_SETS][NUM_WAYS];

  always_comb begin
    found_o  = 1'b0;
    victim_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (!valid_q[set_i][w] || rrpv_q[set_i][w] == DISTANT) begin
        found_o  = 1'b1;
        victim_o = WAY_W'(w);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NUM_SETS; s++) begin
        for (int w = 0; w < NUM_WAYS; w++) begin
          rrpv_q[s][w]  <= '0;
          valid_q[s][w] <= 1'b0;
        end
      end
    end else if (hit_wr_i) begin
      rrpv_q[set_i][way_i] <= '0;
    end else if (fill_i) begin
      rrpv_q[set_i][victim_o]  <= fill_val_i;
      valid_q[set_i][victim_o] <= 1'b1;
    end else if (age_i) begin
      for (int w = 0; w < NUM_WAYS; w++) rrpv_q[set_i][w] <= rrpv_q[set_i][w] + 1'b1;
    end
  end
endmodule

// File: rtl/rrip_repl_ctrl.sv
module rrip_repl_ctrl
  import rrip_pkg::*;
#(
  parameter int NUM_SETS  = 256,
  parameter int NUM_WAYS  = 4,
  parameter int RRPV_BITS = 2,
  parameter int NUM_APPS  = 2,
  parameter int CTR_BITS  = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [$clog2(NUM_SETS)-1:0]   req_set,
  input  logic [$clog2(NUM_WAYS)-1:0]   req_way,
  input  logic                          req_hit,
  input  logic [$clog2(NUM_APPS)-1:0]   req_app,
  input  logic                          duel_en,
  input  logic [RRPV_BITS-1:0]          ins_val,
  input  logic [6:0]                    bip_pct,
  output logic                          busy,
  output logic                          resp_valid,
  output logic [$clog2(NUM_WAYS)-1:0]   resp_way
);
  localparam int SET_W = $clog2(NUM_SETS);
  localparam int WAY_W = $clog2(NUM_WAYS);
  localparam int APP_W = $clog2(NUM_APPS);
  localparam int CW    = CTR_BITS + 2;
  localparam logic [RRPV_BITS-1:0] DISTANT = '1;

  rrip_state_e         st_q;
  logic [SET_W-1:0]    set_q;
  logic [WAY_W-1:0]    way_q;
  logic [APP_W-1:0]    app_q;
  logic                hit_q;

  logic                found, do_hit, do_fill, do_age, use_bimodal;
  logic [WAY_W-1:0]    victim;
  logic [6:0]          rnd_pct;
  logic [RRPV_BITS-1:0] fill_val;
  logic [NUM_APPS*CW-1:0] ctr_flat;

  assign req_ready = (st_q == ST_IDLE);
  assign busy      = (st_q == ST_WORK);
  assign do_hit    = busy && hit_q;
  assign do_fill   = busy && !hit_q && found;
  assign do_age    = busy && !hit_q && !found;

  always_comb begin
    if (!use_bimodal)           fill_val = ins_val;
    else if (rnd_pct < bip_pct) fill_val = ins_val;
    else                        fill_val = DISTANT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q       <= ST_IDLE;
      set_q      <= '0;
      way_q      <= '0;
      app_q      <= '0;
      hit_q      <= 1'b0;
      resp_valid <= 1'b0;
      resp_way   <= '0;
    end else begin
      resp_valid <= 1'b0;
      if (st_q == ST_IDLE) begin
        if (req_valid) begin
          st_q  <= ST_WORK;
          set_q <= req_set;
          way_q <= req_way;
          app_q <= req_app;
          hit_q <= req_hit;
        end
      end else if (do_hit) begin
        st_q       <= ST_IDLE;
        resp_valid <= 1'b1;
        resp_way   <= way_q;
      end else if (do_fill) begin
        st_q       <= ST_IDLE;
        resp_valid <= 1'b1;
        resp_way   <= victim;
      end
    end
  end

  rrip_set_state #(
    .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .RRPV_BITS(RRPV_BITS)
  ) u_state (
    .clk(clk), .rst_n(rst_n), .set_i(set_q), .way_i(way_q),
    .hit_wr_i(do_hit), .age_i(do_age), .fill_i(do_fill),
    .fill_val_i(fill_val), .found_o(found), .victim_o(victim)
  );

  rrip_duel #(
    .NUM_SETS(NUM_SETS), .NUM_APPS(NUM_APPS), .CTR_BITS(CTR_BITS)
  ) u_duel (
    .clk(clk), .rst_n(rst_n), .set_i(set_q), .app_i(app_q),
    .duel_en_i(duel_en), .miss_done_i(do_fill),
    .use_bimodal_o(use_bimodal), .ctr_flat_o(ctr_flat)
  );

  rrip_lfsr #(.LFSR_W(16)) u_lfsr (.clk(clk), .rst_n(rst_n), .pct_o(rnd_pct));
endmodule

// File: rtl/rrip_repl_chk.sv
module rrip_repl_chk #(
  parameter int NUM_APPS  = 2,
  parameter int CTR_BITS  = 3,
  parameter int RRPV_BITS = 2
) (
  input logic                             clk,
  input logic                             rst_n,
  input logic                             req_valid,
  input logic                             req_ready,
  input logic                             req_hit,
  input logic                             busy,
  input logic                             resp_valid,
  input logic                             duel_en,
  input logic [NUM_APPS*(CTR_BITS+2)-1:0] ctr_flat
);
  localparam int CW   = CTR_BITS + 2;
  localparam int CMAX = 2 ** CTR_BITS;
  localparam int BMAX = 2 ** RRPV_BITS;

  int busy_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_cnt <= 0;
    else if (busy) busy_cnt <= busy_cnt + 1;
    else busy_cnt <= 0;
  end

  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> busy && !req_ready);  // R2

  AST_RESP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !resp_valid);  // R2

  AST_HIT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_hit |=> ##1 resp_valid);  // R3

  AST_AGING_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> busy_cnt < BMAX);  // R5

  AST_DUEL_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !duel_en |=> $stable(ctr_flat));  // R12

  for (genvar g = 0; g < NUM_APPS; g++) begin : g_rng
    AST_CTR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      ($signed(ctr_flat[g*CW +: CW]) <= CMAX) &&
      ($signed(ctr_flat[g*CW +: CW]) >= -CMAX));  // R10
  end
endmodule

bind rrip_repl_ctrl rrip_repl_chk #(
  .NUM_APPS(NUM_APPS), .CTR_BITS(CTR_BITS), .RRPV_BITS(RRPV_BITS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .req_hit(req_hit), .busy(busy), .resp_valid(resp_valid),
  .duel_en(duel_en), .ctr_flat(ctr_flat)
);

// File: tb/tb_rrip_repl_ctrl.sv
module tb_rrip_repl_ctrl;
  localparam int NSETS = 256, NWAYS = 4, NB = 2, NAPPS = 2, KB = 3;
  localparam int DIST = 3, STRIDE = 8, CSAT = 8;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_hit = 0, duel_en = 1;
  logic [7:0] req_set = 0;
  logic [1:0] req_way = 0, ins_val = 0;
  logic req_app = 0;
  logic [6:0] bip_pct = 0;
  logic req_ready, busy, resp_valid;
  logic [1:0] resp_way;

  int n_chk = 0, n_fail = 0;
  int m_rrpv [NSETS][NWAYS];
  bit m_val  [NSETS][NWAYS];
  int m_ctr  [NAPPS];

  always #2 clk = ~clk;

  rrip_repl_ctrl #(.NUM_SETS(NSETS), .NUM_WAYS(NWAYS), .RRPV_BITS(NB),
                   .NUM_APPS(NAPPS), .CTR_BITS(KB)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_set(req_set), .req_way(req_way), .req_hit(req_hit), .req_app(req_app),
    .duel_en(duel_en), .ins_val(ins_val), .bip_pct(bip_pct), .busy(busy),
    .resp_valid(resp_valid), .resp_way(resp_way));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one request against the bench model; checks way and latency
  task automatic do_req(int s, int app, bit hit, int way, string req);
    int exp_way, passes, res, lat;
    bit bim, found;
    if (hit) begin
      exp_way = way; passes = 0; m_rrpv[s][way] = 0;
    end else begin
      passes = 0; found = 0; exp_way = 0;
      while (!found) begin
        for (int w = NWAYS - 1; w >= 0; w--)
          if (!m_val[s][w] || m_rrpv[s][w] == DIST) begin found = 1; exp_way = w; end
        if (!found) begin
          for (int w = 0; w < NWAYS; w++) m_rrpv[s][w]++;
          passes++;
        end
      end
      res = s % STRIDE;
      if (!duel_en) bim = 0;
      else if (res == 2 * app) bim = 0;
      else if (res == 2 * app + 1) bim = 1;
      else bim = (m_ctr[app] > 0);
      m_val[s][exp_way] = 1;
      m_rrpv[s][exp_way] = (bim && bip_pct == 0) ? DIST : int'(ins_val);
      if (duel_en && res == 2 * app && m_ctr[app] < CSAT) m_ctr[app]++;
      if (duel_en && res == 2 * app + 1 && m_ctr[app] > -CSAT) m_ctr[app]--;
    end
    req_set = 8'(s); req_app = app[0]; req_hit = hit; req_way = 2'(way); req_valid = 1;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    check("R2 busy after accept", int'(busy && !req_ready), 1);
    lat = 1;
    while (!resp_valid && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    check({req, " way"}, int'(resp_way), exp_way);
    check({req, " latency"}, lat, 2 + passes);
    @(negedge clk);
    check("R2 one-cycle response", int'(resp_valid), 0);
  endtask

  task automatic fill_probe(int s, int app, string req);
    for (int i = 0; i < NWAYS; i++) do_req(s, app, 0, 0, req);
    do_req(s, app, 0, 0, req);
  endtask

  task automatic t_reset;
    check("R1 ready", int'(req_ready), 1);
    check("R1 busy", int'(busy), 0);
    check("R1 resp_valid", int'(resp_valid), 0);
  endtask

  task automatic t_fill_order;  // R4 R6 R7 R5
    duel_en = 1; ins_val = 2; bip_pct = 0;
    fill_probe(4, 0, "R4 lowest victim");
    do_req(4, 0, 0, 0, "R6 fill then R5 aging");
  endtask

  task automatic t_hit;  // R3
    ins_val = 3;
    for (int i = 0; i < NWAYS; i++) do_req(5, 0, 0, 0, "R7 fill");
    do_req(5, 0, 1, 0, "R3 hit response");
    do_req(5, 0, 0, 0, "R3 hit cleared rrpv");
  endtask

  task automatic t_max_age;  // R5
    ins_val = 0;
    fill_probe(6, 1, "R5 max aging passes");
  endtask

  task automatic t_bimodal;  // R8 R9
    ins_val = 1; bip_pct = 0;
    fill_probe(9, 0, "R8 bimodal pct0 leader");
    bip_pct = 100;
    fill_probe(17, 0, "R8 bimodal pct100 leader");
    bip_pct = 0;
    fill_probe(8, 0, "R9 static leader");
  endtask

  task automatic t_counter;  // R10 R11
    ins_val = 0; bip_pct = 0;
    for (int i = 0; i < 8; i++) do_req(1, 0, 0, 0, "R10 down to floor");
    for (int i = 0; i < 9; i++) do_req(0, 0, 0, 0, "R10 up from floor");
    fill_probe(12, 0, "R11 follower after floor");
    fill_probe(20, 1, "R11 other app static");
    for (int i = 0; i < 12; i++) do_req(0, 0, 0, 0, "R10 up to ceiling");
    for (int i = 0; i < 8; i++) do_req(1, 0, 0, 0, "R10 down from ceiling");
    fill_probe(28, 0, "R11 follower after ceiling");
    for (int i = 0; i < 3; i++) do_req(0, 0, 1, i, "R10 hit in leader");
    fill_probe(36, 0, "R10 hits leave counter");
  endtask

  task automatic t_duel_off;  // R12
    duel_en = 0; ins_val = 0; bip_pct = 0;
    fill_probe(33, 0, "R12 leader static when off");
    for (int i = 0; i < 3; i++) do_req(40, 0, 0, 0, "R12 miss when off");
    duel_en = 1;
    fill_probe(44, 0, "R12 counter held");
  endtask

  initial begin
    for (int s = 0; s < NSETS; s++)
      for (int w = 0; w < NWAYS; w++) begin m_rrpv[s][w] = 0; m_val[s][w] = 0; end
    m_ctr[0] = 0; m_ctr[1] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_fill_order();
    t_hit();
    t_max_age();
    t_bimodal();
    t_counter();
    t_duel_off();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule